// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers level-sensitive interrupt requests from on-chip peripherals (timers, a real-time clock, two serial ports, a watchdog, a memory refresh unit, a debug unit, GPIO and DMA channels) plus a 4-bit encoded request from outside the chip. It then presents the single most urgent request to the CPU as an event code and a priority level. Software assigns a 4-bit priority to each group of related sources through three 16-bit priority words. It can also mask individual sources through a mask word that has one address for setting bits and a second address for clearing them.

Every source belongs to one group, and all members of a group share one priority nibble. Every source has a fixed 12-bit event code, with codes spaced 0x20 apart. The external request encodes its own level directly. Arbitration is combinational over the current requests and settings. The result is registered, so the CPU sees a request one clock after the condition that causes it.

Top module: `intc_top`

## Requirements
- R1: After reset, irq_o is 0, irq_code_o and irq_level_o are 0, and every register address reads 0.
- R2: Priority words sit at addresses 0, 1 and 2, and they read back in bits 15:0 with the upper read bits 0. Each nibble is a field, taken from the most significant nibble downward. Word 0 holds timer0, timer1, timer2 and RTC. Word 1 holds watchdog, refresh, serial1 and an unused field. Word 2 holds GPIO, DMA, FIFO serial and debug.
- R3: Sources are numbered by their bit in src_req_i, and each has a fixed event code. Bit 0 is timer0 (0x400) and bit 1 is timer1 (0x420). Bits 2 and 3 are timer2 underflow and capture (0x440, 0x460). Bits 4 to 6 are RTC (0x480, 0x4A0, 0x4C0). Bits 7 to 10 are serial1 (0x4E0 to 0x540). Bit 11 is watchdog (0x560). Bits 12 and 13 are refresh (0x580, 0x5A0). Bit 14 is debug (0x600) and bit 15 is GPIO (0x620). Bits 16 to 19 are DMA transfer-end (0x640 to 0x6A0) and bit 20 is DMA error (0x6C0). Bits 21 to 24 are FIFO serial (0x700 to 0x760).
- R4: Every source of a group requests at its group's field value.
- R5: A source whose group field is 0 never raises irq_o.
- R6: Writing address 3 ORs the written bits into the mask word, where bit i set masks source i. Addresses 3 and 4 both read the mask word.
- R7: Writing address 4 clears each mask bit written as 1 and leaves the other bits unchanged.
- R8: External code 15 means no request. A code n from 0 to 14 requests event code 0x200+0x20·n at level 15−n.
- R9: The pending request with the highest level wins. Among equal levels, the lower event code wins, so the external request wins ties.
- R10: The outputs are registered, so a change in requests or registers shows up one clock edge later. When irq_o is 0, the code and level outputs are 0.
- R11: The unused field (word 1, bits 3:0) is stored and read back but raises no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 25 | Level requests of the on-chip sources, bit i is source i |
| ext_lvl_i | input | 4 | Encoded external request, 15 = idle |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 25 | Write data |
| bus_rdata_o | output | 25 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request to the CPU |
| irq_code_o | output | 12 | Event code of the winner |
| irq_level_o | output | 4 | Level of the winner |

## Verification
The bench sweeps every source alone at its own group field and every external code. It would catch a wrong nibble-to-group map, an off-by-0x20 code, or an inverted external level. Ties between members of one group, and between the external request and an internal source, expose a comparator that uses ≥ in place of >, which would hand the win to the later, higher code. Partial write-one-to-clear patterns would show a mask that overwrites instead of clearing. The unused nibble and zero-priority fields would show a design that lets field 0 or the spare field request. A long sequence of pseudo-random settings is compared with an arithmetic model.

// File: rtl/intc_pkg.sv
// Package: shared constants and the fixed source tables of the interrupt controller.
// Assumes 25 on-chip sources and 12 priority fields held in three 16-bit words.
package intc_pkg;
    localparam int NUM_SRC   = 25;
    localparam int LVL_W     = 4;
    localparam int CODE_W    = 12;
    localparam int PRIO_W    = 16;
    localparam int NUM_PRIO  = 3;
    localparam int FLD_PER_W = PRIO_W / LVL_W;
    localparam int BUS_W     = NUM_SRC;
    localparam int ADDR_W    = 3;
    localparam logic [LVL_W-1:0] EXT_IDLE = 4'hF;

    // Event code of on-chip source i (codes spaced 0x20 inside three runs)
    function automatic logic [CODE_W-1:0] src_code(input int i);
        int base;
        int off;
        if (i < 14) begin
            base = 'h400; off = i;
        end else if (i < 21) begin
            base = 'h600; off = i - 14;
        end else begin
            base = 'h700; off = i - 21;
        end
        return CODE_W'(base + 32 * off);
    endfunction

    // Priority field index (word*4 + nibble slot, slot 0 = top nibble) of source i
    function automatic int src_field(input int i);
        int f;
        if (i == 0)       f = 0;
        else if (i == 1)  f = 1;
        else if (i <= 3)  f = 2;
        else if (i <= 6)  f = 3;
        else if (i <= 10) f = 6;
        else if (i == 11) f = 4;
        else if (i <= 13) f = 5;
        else if (i == 14) f = 11;
        else if (i == 15) f = 8;
        else if (i <= 20) f = 9;
        else              f = 10;
        return f;
    endfunction
endpackage

// File: rtl/intc_regs.sv
// Register file: priority words and the mask word with set and clear addresses.
// Assumes single-cycle writes; reads are a combinational mux on the address.
module intc_regs
    import intc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [BUS_W-1:0]           wdata,
    output logic [BUS_W-1:0]           rdata,
    output logic [NUM_PRIO*PRIO_W-1:0] prio_flat,
    output logic [NUM_SRC-1:0]         mask_q
);
    localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(NUM_PRIO);
    localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(NUM_PRIO + 1);

    logic [PRIO_W-1:0] prio_q [NUM_PRIO];

    genvar g;
    generate
        for (g = 0; g < NUM_PRIO; g++) begin : g_prio
            // Hold one priority word, loaded by a write to its address
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prio_q[g] <= '0;
                else if (we && addr == ADDR_W'(g))
                    prio_q[g] <= wdata[PRIO_W-1:0];
            end
            assign prio_flat[g*PRIO_W +: PRIO_W] = prio_q[g];
        end
    endgenerate

    // Mask word: OR on the set address, write-one-to-clear on the clear address
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (we && addr == A_MSET)
            mask_q <= mask_q | wdata;
        else if (we && addr == A_MCLR)
            mask_q <= mask_q & ~wdata;
    end

    // Read mux over all register addresses
    always_comb begin
        rdata = '0;
        if (addr == A_MSET || addr == A_MCLR)
            rdata = mask_q;
        else
            for (int k = 0; k < NUM_PRIO; k++)
                if (addr == ADDR_W'(k))
                    rdata = BUS_W'(prio_q[k]);
    end
endmodule

// File: rtl/intc_level_map.sv
// Level map: gives each on-chip source its effective level (0 when idle or masked).
// Assumes the field table in intc_pkg; all members of a group share one nibble.
module intc_level_map
    import intc_pkg::*;
(
    input  logic [NUM_SRC-1:0]         src_req,
    input  logic [NUM_SRC-1:0]         mask_q,
    input  logic [NUM_PRIO*PRIO_W-1:0] prio_flat,
    output logic [NUM_SRC*LVL_W-1:0]   src_lvl
);
    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_src
            localparam int FLD  = src_field(g);
            localparam int WRD  = FLD / FLD_PER_W;
            localparam int SLOT = FLD % FLD_PER_W;
            localparam int LSB  = WRD * PRIO_W + PRIO_W - LVL_W * (SLOT + 1);
            // Pass the group field only for a live, unmasked request
            assign src_lvl[g*LVL_W +: LVL_W] =
                (src_req[g] && !mask_q[g]) ? prio_flat[LSB +: LVL_W] : '0;
        end
    endgenerate
endmodule

// File: rtl/intc_arbiter.sv
// Arbiter: picks the highest level, lowest event code among all requests.
// Assumes candidates are scanned in ascending code order (external first).
module intc_arbiter
    import intc_pkg::*;
(
    input  logic [NUM_SRC*LVL_W-1:0] src_lvl,
    input  logic [LVL_W-1:0]         ext_lvl,
    output logic                     win_valid,
    output logic [CODE_W-1:0]        win_code,
    output logic [LVL_W-1:0]         win_lvl
);
    // Linear scan; a later candidate replaces the best only if strictly higher
    always_comb begin
        if (ext_lvl != EXT_IDLE) begin
            win_lvl  = EXT_IDLE - ext_lvl;
            win_code = CODE_W'('h200) + {3'b000, ext_lvl, 5'b00000};
        end else begin
            win_lvl  = '0;
            win_code = '0;
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_lvl[i*LVL_W +: LVL_W] > win_lvl) begin
                win_lvl  = src_lvl[i*LVL_W +: LVL_W];
                win_code = src_code(i);
            end
        end
        win_valid = (win_lvl != '0);
    end
endmodule

// File: rtl/intc_top.sv
// Top: prioritised vectored interrupt controller with registered CPU outputs.
// Assumes synchronous active-low reset; request inputs are already synchronous.
module intc_top
    import intc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_req_i,
    input  logic [LVL_W-1:0]    ext_lvl_i,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [BUS_W-1:0]    bus_wdata_i,
    output logic [BUS_W-1:0]    bus_rdata_o,
    output logic                irq_o,
    output logic [CODE_W-1:0]   irq_code_o,
    output logic [LVL_W-1:0]    irq_level_o
);
    logic [NUM_PRIO*PRIO_W-1:0] prio_flat;
    logic [NUM_SRC-1:0]         mask_q;
    logic [NUM_SRC*LVL_W-1:0]   src_lvl;
    logic                       win_valid;
    logic [CODE_W-1:0]          win_code;
    logic [LVL_W-1:0]           win_lvl;

    intc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we_i),
        .addr      (bus_addr_i),
        .wdata     (bus_wdata_i),
        .rdata     (bus_rdata_o),
        .prio_flat (prio_flat),
        .mask_q    (mask_q)
    );

    intc_level_map u_map (
        .src_req   (src_req_i),
        .mask_q    (mask_q),
        .prio_flat (prio_flat),
        .src_lvl   (src_lvl)
    );

    intc_arbiter u_arb (
        .src_lvl   (src_lvl),
        .ext_lvl   (ext_lvl_i),
        .win_valid (win_valid),
        .win_code  (win_code),
        .win_lvl   (win_lvl)
    );

    // Register the winner toward the CPU; code and level are zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o       <= 1'b0;
            irq_code_o  <= '0;
            irq_level_o <= '0;
        end else begin
            irq_o       <= win_valid;
            irq_code_o  <= win_valid ? win_code : '0;
            irq_level_o <= win_valid ? win_lvl  : '0;
        end
    end
endmodule

// File: rtl/intc_checker.sv
// Checker: temporal properties of the controller's outputs and mask word.
// Assumes it is bound into intc_top and sees the internal mask word.
module intc_checker
    import intc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [BUS_W-1:0]   bus_wdata_i,
    input  logic [NUM_SRC-1:0] mask_q,
    input  logic               irq_o,
    input  logic [CODE_W-1:0]  irq_code_o,
    input  logic [LVL_W-1:0]   irq_level_o
);
    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_code_o == '0 && irq_level_o == '0));

    assert_level_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_level_o != '0);

    assert_code_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_code_o[4:0] == 5'd0 && irq_code_o >= CODE_W'('h200)));

    assert_ext_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && irq_code_o[11:9] == 3'b001) |-> irq_level_o == EXT_IDLE - irq_code_o[8:5]);

    assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_we_i) && $past(bus_addr_i) == ADDR_W'(NUM_PRIO))
        |-> (mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i));

    assert_mask_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bus_we_i) && $past(bus_addr_i) == ADDR_W'(NUM_PRIO + 1))
        |-> ((mask_q & $past(bus_wdata_i)) == '0
             && (mask_q | $past(bus_wdata_i)) == ($past(mask_q) | $past(bus_wdata_i))));
endmodule

bind intc_top intc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .mask_q      (mask_q),
    .irq_o       (irq_o),
    .irq_code_o  (irq_code_o),
    .irq_level_o (irq_level_o)
);

// File: tb/tb_intc_top.sv
module tb_intc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [24:0] src_req_i = '0;
    logic [3:0]  ext_lvl_i = 4'hF;
    logic        bus_we_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic [24:0] bus_wdata_i = '0;
    logic [24:0] bus_rdata_o;
    logic        irq_o;
    logic [11:0] irq_code_o;
    logic [3:0]  irq_level_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [15:0] p_m [3];
    logic [24:0] m_m;
    logic [31:0] rng = 32'h1357_9BDF;

    always #2 clk = ~clk;

    intc_top dut (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req_i), .ext_lvl_i(ext_lvl_i),
        .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .irq_code_o(irq_code_o),
        .irq_level_o(irq_level_o)
    );

    function automatic int code_of(input int i);
        case (i)
            0: return 'h400;  1: return 'h420;  2: return 'h440;  3: return 'h460;
            4: return 'h480;  5: return 'h4A0;  6: return 'h4C0;  7: return 'h4E0;
            8: return 'h500;  9: return 'h520;  10: return 'h540; 11: return 'h560;
            12: return 'h580; 13: return 'h5A0; 14: return 'h600; 15: return 'h620;
            16: return 'h640; 17: return 'h660; 18: return 'h680; 19: return 'h6A0;
            20: return 'h6C0; 21: return 'h700; 22: return 'h720; 23: return 'h740;
            default: return 'h760;
        endcase
    endfunction

    // field index: word*4 + slot, slot 0 = bits 15:12
    function automatic int fld_of(input int i);
        case (i)
            0: return 0; 1: return 1; 2, 3: return 2; 4, 5, 6: return 3;
            7, 8, 9, 10: return 6; 11: return 4; 12, 13: return 5; 14: return 11;
            15: return 8; 16, 17, 18, 19, 20: return 9; default: return 10;
        endcase
    endfunction

    function automatic int field_val(input int f);
        return (p_m[f / 4] >> (12 - 4 * (f % 4))) & 15;
    endfunction

    task automatic model(output int v, output int code, output int lvl);
        int bl = 0, bc = 0;
        if (ext_lvl_i != 4'hF) begin
            bl = 15 - ext_lvl_i;
            bc = 'h200 + 32 * ext_lvl_i;
        end
        for (int i = 0; i < 25; i++) begin
            int l;
            l = (src_req_i[i] && !m_m[i]) ? field_val(fld_of(i)) : 0;
            if (l > bl || (l == bl && l != 0 && code_of(i) < bc)) begin
                bl = l; bc = code_of(i);
            end
        end
        v = (bl != 0); code = v ? bc : 0; lvl = bl;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [24:0] d);
        @(negedge clk);
        bus_we_i = 1; bus_addr_i = 3'(a); bus_wdata_i = d;
        @(negedge clk);
        bus_we_i = 0; bus_wdata_i = '0;
        if (a < 3) p_m[a] = d[15:0];
        else if (a == 3) m_m = m_m | d;
        else if (a == 4) m_m = m_m & ~d;
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        bus_addr_i = 3'(a);
        #1;
        chk(tag, int'(bus_rdata_o), exp);
    endtask

    // inputs already applied; one edge later compare the outputs with the model
    task automatic out_chk(input string tag);
        int v, c, l;
        model(v, c, l);
        @(negedge clk);
        chk({tag, " irq"}, int'(irq_o), v);
        chk({tag, " code"}, int'(irq_code_o), c);
        chk({tag, " level"}, int'(irq_level_o), l);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        p_m[0] = 0; p_m[1] = 0; p_m[2] = 0; m_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 code", int'(irq_code_o), 0);
        chk("R1 level", int'(irq_level_o), 0);
        for (int a = 0; a < 8; a++) rd_chk("R1 read", a, 0);

        // R2: priority readback, upper bits zero
        wr(0, 25'h1FF_A5C3);
        rd_chk("R2 word0", 0, 'hA5C3);
        wr(1, 25'h0_1234);
        rd_chk("R2 word1", 1, 'h1234);
        wr(2, 25'h0_FEDC);
        rd_chk("R2 word2", 2, 'hFEDC);

        // R3 R4 R2: each source alone at its own field only
        for (int i = 0; i < 25; i++) begin
            int f, lv;
            logic [15:0] w [3];
            f = fld_of(i); lv = (i % 15) + 1;
            w[0] = 0; w[1] = 0; w[2] = 0;
            w[f / 4] = 16'(lv << (12 - 4 * (f % 4)));
            wr(0, {9'd0, w[0]}); wr(1, {9'd0, w[1]}); wr(2, {9'd0, w[2]});
            src_req_i = 25'(1) << i;
            out_chk("R3 R4 single source");
        end

        // R5: all fields zero disables every source
        wr(0, 0); wr(1, 0); wr(2, 0);
        src_req_i = '1;
        out_chk("R5 zero priority");

        // R11: spare nibble set, all sources on, still nothing
        wr(1, 25'h000F);
        rd_chk("R11 readback", 1, 'h000F);
        out_chk("R11 unused field");
        chk("R11 irq low", int'(irq_o), 0);

        // R8: external code sweep, on-chip quiet
        src_req_i = '0;
        for (int n = 0; n < 16; n++) begin
            ext_lvl_i = 4'(n);
            out_chk("R8 external");
            if (n < 15) chk("R8 code", int'(irq_code_o), 'h200 + 32 * n);
        end
        ext_lvl_i = 4'hF;

        // R6 R7: mask set then partial clear
        wr(0, 25'h0007);              // RTC field = 7
        wr(3, 25'h0F0);
        rd_chk("R6 mask read", 3, 'h0F0);
        rd_chk("R6 mask read alt", 4, 'h0F0);
        src_req_i = 25'h20;           // RTC periodic, masked
        out_chk("R6 masked");
        chk("R6 irq low", int'(irq_o), 0);
        wr(3, 25'h100);
        rd_chk("R6 mask or", 3, 'h1F0);
        wr(4, 25'h30);
        rd_chk("R7 clear keep", 3, 'h1C0);
        out_chk("R7 unmasked");
        chk("R7 code", int'(irq_code_o), 'h4A0);
        wr(4, 25'h1FF_FFFF);
        rd_chk("R7 clear all", 3, 0);

        // R9: ties and priority order
        wr(0, 25'h5555); wr(1, 25'h5550); wr(2, 25'h5555);
        src_req_i = 25'h3;
        out_chk("R9 tie lower code");
        chk("R9 tie code", int'(irq_code_o), 'h400);
        src_req_i = 25'h30;           // two RTC members, same field
        out_chk("R9 group tie");
        chk("R9 group tie code", int'(irq_code_o), 'h480);
        src_req_i = 25'h1; ext_lvl_i = 4'd10;   // ext level 5, code 0x340
        out_chk("R9 ext tie");
        chk("R9 ext tie code", int'(irq_code_o), 'h340);
        ext_lvl_i = 4'hF;
        wr(0, 25'h5955);
        src_req_i = 25'h3;
        out_chk("R9 higher wins");
        chk("R9 higher code", int'(irq_code_o), 'h420);

        // R10: latency of one edge
        wr(0, 0); wr(1, 0); wr(2, 0);
        src_req_i = '0;
        @(negedge clk);
        wr(2, 25'h00F0);              // FIFO serial field = 15
        @(negedge clk);
        src_req_i = 25'h1 << 22;
        #1;
        chk("R10 before edge", int'(irq_o), 0);
        @(negedge clk);
        chk("R10 after edge", int'(irq_o), 1);
        chk("R10 code", int'(irq_code_o), 'h720);

        // R9: pseudo-random sweep against the model
        for (int it = 0; it < 400; it++) begin
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            if (it % 4 == 0) begin
                wr(it % 3, {9'd0, rng[31:16]});
                if (rng[3]) wr(3, 25'(rng >> 5) & 25'(rng >> 2));
                else wr(4, 25'(rng >> 7));
            end
            src_req_i = 25'(rng);
            ext_lvl_i = rng[30] ? 4'hF : rng[29:26];
            out_chk("R9 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule